// File: doc/BRIEF.md
# Parallel-Plane Match Count Recorder

This block keeps the central scheduler's records for a switch built from several identical planes that all forward cells under one shared input-to-output pairing in each cell slot. The pairing arrives from an external matcher as one target output per input plus a valid bit. Each plane supplies a one-bit occupancy flag for each of its per-pair queues, showing whether that queue holds a cell. The block copies the pairing to every plane. For each matched pair, it counts how many planes will move a cell.

Each output has its own short count list, and the block appends the cell count for a matched pair to the list of that pair's output. The output's reassembly stage pops an entry when it has read that group of cells. When fewer cells move than there are planes, the block sends two one-cycle messages. One goes to the input's spreader and names the output, so the spreader can send that flow's next cell to plane 0 again. The other goes to the output's reassembly stage and carries the short count. When every plane moves a cell, neither message is sent.

Top module: `mcr_match_recorder`

## Requirements
- R1: One clock after a slot with `slot_valid` high, every plane copy `l` shows `plane_vld[l*N+i] = match_vld[i]` and `plane_out` slice `l*N+i` equal to the target output of input `i`. One clock after a slot with `slot_valid` low, all of `plane_vld` is zero.
- R2: The count `p` for a matched pair (input i, output j) is the number of planes `l` whose occupancy flag `voq_nonempty[(l*N+i)*N+j]` is 1.
- R3: A matched pair with `p >= 1` appends `p` to the list of output j. `list_avail[j]` and `list_head[j]` show the oldest entry one clock after the slot, and entries come out in the order they were appended.
- R4: When `1 <= p < K`, `dmx_rst_vld[i]` is high for exactly the clock after the slot, and `dmx_rst_out` slice i holds j.
- R5: When `1 <= p < K`, `mux_req[j]` is high for the clock after the slot, and `mux_cnt` slice j holds p. When `p = K`, neither `mux_req[j]` nor `dmx_rst_vld[i]` is raised. `mux_cnt[j]` is zero whenever `mux_req[j]` is low.
- R6: No append and no message is produced for an input whose match bit is clear, for any input while `slot_valid` is low, or for a matched pair with `p = 0`.
- R7: A high `mux_pop[j]` removes the head of list j at the next clock. A pop of an empty list has no effect.
- R8: An append to a full list with no pop in the same clock is dropped and sets `list_ovf[j]`, which stays set until reset. An append and a pop in the same clock on a full list are both accepted.
- R9: While reset is held, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 1 | A pairing is applied in this cell slot |
| match_vld | input | N | Input i is matched |
| match_out | input | N*IW | Target output of each input, IW bits per input |
| voq_nonempty | input | K*N*N | Plane occupancy flags, bit (l*N+i)*N+j |
| mux_pop | input | N | Reassembly stage j has finished the group at its list head |
| plane_vld | output | K*N | Copied match bits, one set per plane |
| plane_out | output | K*N*IW | Copied target outputs, one set per plane |
| dmx_rst_vld | output | N | Pointer-return message to spreader i |
| dmx_rst_out | output | N*IW | Output index carried with the message to spreader i |
| mux_req | output | N | Short-count request to reassembly stage j |
| mux_cnt | output | N*CW | Count carried with the request |
| list_head | output | N*CW | Oldest entry of list j |
| list_avail | output | N | List j holds at least one entry |
| list_ovf | output | N | Sticky overflow flag of list j |

## Verification
The checker takes the pairing to be one-to-one: at most one matched input names a given output in any slot. When two inputs claim the same output, the block keeps only the lowest-numbered one, and the checker's message pairing rule depends on that inputs never do this. The stimulus obeys the rule by applying either a single matched pair or a rotation of all inputs. The occupancy flags are never restricted: every flag pattern of the matched pair is swept, and the flags of unmatched pairs are held at 1 so that any leak into a count would show up.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
    localparam int MAX_PLANES = 32;

    function automatic int unsigned ones_in(input logic [MAX_PLANES-1:0] v);
        int unsigned n;
        n = 0;
        for (int b = 0; b < MAX_PLANES; b++) begin
            n += int'(v[b]);
        end
        return n;
    endfunction
endpackage

// File: rtl/mcr_popcount.sv
module mcr_popcount #(
    parameter int K_PLANES = 3,
    parameter int CW       = $clog2(K_PLANES + 1)
) (
    input  logic [K_PLANES-1:0] bits_in,
    output logic [CW-1:0]       count
);
    import mcr_pkg::*;

    always_comb begin
        count = CW'(ones_in(MAX_PLANES'(bits_in)));
    end
endmodule

// File: rtl/mcr_list_fifo.sv
module mcr_list_fifo #(
    parameter int W     = 2,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         avail,
    output logic         ovf
);
    localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [CTW-1:0]          cnt;
        logic                    ovf;
    } fst_t;

    fst_t st_d, st_q;

    always_comb begin
        logic do_pop, room, do_push;
        int   wi;
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        room    = (st_q.cnt < CTW'(DEPTH)) || do_pop;
        do_push = push && room;
        wi      = (int'(st_q.rd) + int'(st_q.cnt)) % DEPTH;
        if (do_push) begin
            st_d.mem[PW'(wi)] = push_data;
        end
        if (push && !room) begin
            st_d.ovf = 1'b1;
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        st_d.cnt = st_q.cnt + CTW'(do_push) - CTW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rd];
    assign avail = (st_q.cnt != '0);
    assign ovf   = st_q.ovf;
endmodule

// File: rtl/mcr_match_recorder.sv
module mcr_match_recorder #(
    parameter int N_PORTS  = 4,
    parameter int K_PLANES = 3,
    parameter int DEPTH    = 4,
    parameter int IW       = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
    parameter int CW       = $clog2(K_PLANES + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           slot_valid,
    input  logic [N_PORTS-1:0]             match_vld,
    input  logic [N_PORTS*IW-1:0]          match_out,
    input  logic [K_PLANES*N_PORTS*N_PORTS-1:0] voq_nonempty,
    input  logic [N_PORTS-1:0]             mux_pop,
    output logic [K_PLANES*N_PORTS-1:0]    plane_vld,
    output logic [K_PLANES*N_PORTS*IW-1:0] plane_out,
    output logic [N_PORTS-1:0]             dmx_rst_vld,
    output logic [N_PORTS*IW-1:0]          dmx_rst_out,
    output logic [N_PORTS-1:0]             mux_req,
    output logic [N_PORTS*CW-1:0]          mux_cnt,
    output logic [N_PORTS*CW-1:0]          list_head,
    output logic [N_PORTS-1:0]             list_avail,
    output logic [N_PORTS-1:0]             list_ovf
);
    localparam int PN = K_PLANES * N_PORTS;

    typedef struct packed {
        logic [N_PORTS-1:0]          dmx_vld;
        logic [N_PORTS-1:0][IW-1:0]  dmx_out;
        logic [N_PORTS-1:0]          req;
        logic [N_PORTS-1:0][CW-1:0]  cnt;
        logic [PN-1:0]               pl_vld;
        logic [PN-1:0][IW-1:0]       pl_out;
    } st_t;

    st_t st_d, st_q;

    logic [N_PORTS-1:0]         out_push;
    logic [N_PORTS-1:0]         out_low;
    logic [N_PORTS-1:0][IW-1:0] out_src;
    logic [N_PORTS-1:0][CW-1:0] out_p;

    for (genvar j = 0; j < N_PORTS; j++) begin : g_out
        logic               hit_j;
        logic [IW-1:0]      src_j;
        logic [K_PLANES-1:0] tags_j;
        logic [CW-1:0]      p_j;

        always_comb begin
            hit_j = 1'b0;
            src_j = '0;
            for (int i = N_PORTS - 1; i >= 0; i--) begin
                if (slot_valid && match_vld[i] &&
                    match_out[i*IW +: IW] == IW'(j)) begin
                    hit_j = 1'b1;
                    src_j = IW'(i);
                end
            end
            for (int l = 0; l < K_PLANES; l++) begin
                tags_j[l] = voq_nonempty[(l*N_PORTS + int'(src_j))*N_PORTS + j];
            end
        end

        mcr_popcount #(.K_PLANES(K_PLANES), .CW(CW)) u_pc (
            .bits_in (tags_j),
            .count   (p_j)
        );

        assign out_push[j] = hit_j && (p_j != '0);
        assign out_low[j]  = out_push[j] && (p_j < CW'(K_PLANES));
        assign out_src[j]  = src_j;
        assign out_p[j]    = p_j;

        mcr_list_fifo #(.W(CW), .DEPTH(DEPTH)) u_list (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (out_push[j]),
            .push_data (p_j),
            .pop       (mux_pop[j]),
            .head      (list_head[j*CW +: CW]),
            .avail     (list_avail[j]),
            .ovf       (list_ovf[j])
        );
    end

    always_comb begin
        st_d = '0;
        for (int j = 0; j < N_PORTS; j++) begin
            st_d.req[j] = out_low[j];
            st_d.cnt[j] = out_low[j] ? out_p[j] : '0;
            if (out_low[j]) begin
                st_d.dmx_vld[out_src[j]] = 1'b1;
                st_d.dmx_out[out_src[j]] = IW'(j);
            end
        end
        for (int l = 0; l < K_PLANES; l++) begin
            for (int i = 0; i < N_PORTS; i++) begin
                st_d.pl_vld[l*N_PORTS + i] = slot_valid && match_vld[i];
                st_d.pl_out[l*N_PORTS + i] = slot_valid ? match_out[i*IW +: IW] : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign plane_vld   = st_q.pl_vld;
    assign plane_out   = st_q.pl_out;
    assign dmx_rst_vld = st_q.dmx_vld;
    assign dmx_rst_out = st_q.dmx_out;
    assign mux_req     = st_q.req;
    assign mux_cnt     = st_q.cnt;
endmodule

// File: rtl/mcr_match_recorder_chk.sv
module mcr_match_recorder_chk #(
    parameter int N_PORTS  = 4,
    parameter int K_PLANES = 3,
    parameter int CW       = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        slot_valid,
    input logic [N_PORTS-1:0]          match_vld,
    input logic [K_PLANES*N_PORTS-1:0] plane_vld,
    input logic [N_PORTS-1:0]          dmx_rst_vld,
    input logic [N_PORTS-1:0]          mux_req,
    input logic [N_PORTS*CW-1:0]       mux_cnt,
    input logic [N_PORTS-1:0]          list_avail,
    input logic [N_PORTS-1:0]          list_ovf
);
    AST_PLANE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |=> plane_vld == {K_PLANES{$past(match_vld)}}); // R1
    AST_PLANE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_valid |=> plane_vld == '0); // R1
    AST_MSG_PAIRING: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dmx_rst_vld) == $countones(mux_req)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_valid |=> (mux_req == '0 && dmx_rst_vld == '0)); // R6

    for (genvar j = 0; j < N_PORTS; j++) begin : g_chk
        AST_SHORT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
            mux_req[j] |-> (mux_cnt[j*CW +: CW] != '0 &&
                            mux_cnt[j*CW +: CW] < CW'(K_PLANES))); // R5
        AST_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !mux_req[j] |-> mux_cnt[j*CW +: CW] == '0); // R5
        AST_REQ_LISTED: assert property (@(posedge clk) disable iff (!rst_n)
            mux_req[j] |-> list_avail[j]); // R3
        AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            list_ovf[j] |=> list_ovf[j]); // R8
    end
endmodule

bind mcr_match_recorder mcr_match_recorder_chk #(
    .N_PORTS(N_PORTS), .K_PLANES(K_PLANES), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .match_vld(match_vld),
    .plane_vld(plane_vld), .dmx_rst_vld(dmx_rst_vld), .mux_req(mux_req),
    .mux_cnt(mux_cnt), .list_avail(list_avail), .list_ovf(list_ovf)
);

// File: tb/mcr_match_recorder_test.sv
`timescale 1ns/1ps
module mcr_match_recorder_test;
    localparam int N  = 4;
    localparam int K  = 3;
    localparam int D  = 4;
    localparam int IW = 2;
    localparam int CW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_valid = 1'b0;
    logic [N-1:0] match_vld = '0;
    logic [N*IW-1:0] match_out = '0;
    logic [K*N*N-1:0] voq_nonempty = '0;
    logic [N-1:0] mux_pop = '0;
    logic [K*N-1:0] plane_vld;
    logic [K*N*IW-1:0] plane_out;
    logic [N-1:0] dmx_rst_vld;
    logic [N*IW-1:0] dmx_rst_out;
    logic [N-1:0] mux_req;
    logic [N*CW-1:0] mux_cnt;
    logic [N*CW-1:0] list_head;
    logic [N-1:0] list_avail;
    logic [N-1:0] list_ovf;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mcr_match_recorder #(.N_PORTS(N), .K_PLANES(K), .DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .match_vld(match_vld),
        .match_out(match_out), .voq_nonempty(voq_nonempty), .mux_pop(mux_pop),
        .plane_vld(plane_vld), .plane_out(plane_out), .dmx_rst_vld(dmx_rst_vld),
        .dmx_rst_out(dmx_rst_out), .mux_req(mux_req), .mux_cnt(mux_cnt),
        .list_head(list_head), .list_avail(list_avail), .list_ovf(list_ovf)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int tix(int l, int i, int j);
        return (l*N + i)*N + j;
    endfunction

    task automatic idle_inputs();
        slot_valid = 1'b0; match_vld = '0; match_out = '0; mux_pop = '0;
    endtask

    // one matched pair i->j with plane flag pattern pat; all other flags 1
    task automatic single(input int i, input int j, input int pat);
        voq_nonempty = '1;
        for (int l = 0; l < K; l++) voq_nonempty[tix(l, i, j)] = pat[l];
        slot_valid = 1'b1;
        match_vld = '0; match_vld[i] = 1'b1;
        match_out = '0; match_out[i*IW +: IW] = IW'(j);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R9: outputs are zero while reset is held
        step();
        chk(plane_vld == 0 && dmx_rst_vld == 0 && mux_req == 0 && mux_cnt == 0 &&
            list_avail == 0 && list_ovf == 0 && plane_out == 0 && dmx_rst_out == 0,
            "R9 reset", {plane_vld, mux_req, list_avail}, 0);
        rst_n = 1'b1;
        step();

        // Sweep every pair and every flag pattern
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                for (int pat = 0; pat < 8; pat++) begin
                    int p;
                    bit low;
                    p = $countones(pat[K-1:0]);
                    low = (p > 0) && (p < K);
                    single(i, j, pat);
                    step();
                    chk(plane_vld == {K{4'(1 << i)}}, "R1 plane_vld", plane_vld, {K{4'(1 << i)}});
                    for (int l = 0; l < K; l++)
                        chk(plane_out[(l*N+i)*IW +: IW] == IW'(j), "R1 plane_out",
                            plane_out[(l*N+i)*IW +: IW], j);
                    chk(mux_req == (low ? 4'(1 << j) : 4'd0), "R5 mux_req", mux_req,
                        low ? (1 << j) : 0);
                    chk(mux_cnt[j*CW +: CW] == (low ? CW'(p) : CW'(0)), "R5 mux_cnt",
                        mux_cnt[j*CW +: CW], low ? p : 0);
                    chk(dmx_rst_vld == (low ? 4'(1 << i) : 4'd0), "R4 dmx_rst_vld",
                        dmx_rst_vld, low ? (1 << i) : 0);
                    if (low)
                        chk(dmx_rst_out[i*IW +: IW] == IW'(j), "R4 dmx_rst_out",
                            dmx_rst_out[i*IW +: IW], j);
                    chk(list_avail == (p > 0 ? 4'(1 << j) : 4'd0), "R6 list_avail",
                        list_avail, p > 0 ? (1 << j) : 0);
                    if (p > 0)
                        chk(list_head[j*CW +: CW] == CW'(p), "R2 list_head",
                            list_head[j*CW +: CW], p);
                    idle_inputs();
                    mux_pop = 4'(1 << j);
                    step();
                    chk(list_avail == 0, "R7 pop drains", list_avail, 0);
                    chk(plane_vld == 0 && mux_req == 0 && dmx_rst_vld == 0,
                        "R1 quiet after slot", {plane_vld, mux_req}, 0);
                    mux_pop = '0;
                end
            end
        end

        // Full rotations: input i -> (i+s)%N, pattern per pair
        for (int s = 0; s < N; s++) begin
            voq_nonempty = '1;
            slot_valid = 1'b1;
            match_vld = '1;
            for (int i = 0; i < N; i++) begin
                int j;
                j = (i + s) % N;
                match_out[i*IW +: IW] = IW'(j);
                for (int l = 0; l < K; l++)
                    voq_nonempty[tix(l, i, j)] = ((i + 2*s + j) >> l) & 1;
            end
            step();
            for (int j = 0; j < N; j++) begin
                int i, pat, p;
                bit low;
                i = (j - s + N) % N;
                pat = (i + 2*s + j) % 8;
                p = $countones(pat[K-1:0]);
                low = (p > 0) && (p < K);
                chk(list_avail[j] == (p > 0), "R3 rotation avail", list_avail[j], p > 0);
                if (p > 0)
                    chk(list_head[j*CW +: CW] == CW'(p), "R2 rotation count",
                        list_head[j*CW +: CW], p);
                chk(mux_req[j] == low, "R5 rotation req", mux_req[j], low);
                chk(dmx_rst_vld[i] == low, "R4 rotation dmx", dmx_rst_vld[i], low);
                if (low)
                    chk(dmx_rst_out[i*IW +: IW] == IW'(j), "R4 rotation index",
                        dmx_rst_out[i*IW +: IW], j);
            end
            idle_inputs();
            mux_pop = '1;
            step();
            mux_pop = '0;
            chk(list_avail == 0, "R7 rotation drain", list_avail, 0);
        end

        // R6: slot_valid low with matches present
        voq_nonempty = '1;
        match_vld = '1;
        match_out = {2'd3, 2'd2, 2'd1, 2'd0};
        slot_valid = 1'b0;
        step();
        chk(mux_req == 0 && dmx_rst_vld == 0 && plane_vld == 0 && list_avail == 0,
            "R6 idle slot", {mux_req, dmx_rst_vld, list_avail}, 0);
        idle_inputs();

        // R8: overflow on output 0 from input 2, counts 1,2,3,1,2
        begin
            int seq[5] = '{1, 3, 7, 1, 3};
            int exp_c[4] = '{1, 2, 3, 1};
            for (int n = 0; n < 5; n++) begin
                single(2, 0, seq[n]);
                step();
                if (n == 3) chk(list_ovf[0] == 1'b0, "R8 no ovf at full", list_ovf[0], 0);
            end
            idle_inputs();
            step();
            chk(list_ovf == 4'b0001, "R8 ovf set", list_ovf, 1);
            for (int n = 0; n < 4; n++) begin
                chk(list_head[0 +: CW] == CW'(exp_c[n]), "R3 fifo order",
                    list_head[0 +: CW], exp_c[n]);
                mux_pop = 4'b0001;
                step();
                mux_pop = '0;
            end
            chk(list_avail[0] == 1'b0, "R8 dropped entry absent", list_avail[0], 0);
            mux_pop = 4'b0001;
            step();
            mux_pop = '0;
            chk(list_avail[0] == 1'b0 && list_ovf[0] == 1'b1, "R7 pop on empty",
                {list_avail[0], list_ovf[0]}, 2'b01);
            single(1, 0, 3);
            step();
            idle_inputs();
            chk(list_avail[0] && list_head[0 +: CW] == 2'd2, "R7 list intact after empty pop",
                list_head[0 +: CW], 2);
        end

        // R8: full list with push and pop in the same clock on output 1
        for (int n = 0; n < 4; n++) begin
            single(3, 1, 7);
            step();
        end
        single(3, 1, 1);
        mux_pop = 4'b0010;
        step();
        idle_inputs();
        chk(list_ovf[1] == 1'b0, "R8 push with pop on full", list_ovf[1], 0);
        begin
            int exp_c[4] = '{3, 3, 3, 1};
            for (int n = 0; n < 4; n++) begin
                chk(list_head[CW +: CW] == CW'(exp_c[n]), "R8 order after full push",
                    list_head[CW +: CW], exp_c[n]);
                mux_pop = 4'b0010;
                step();
                mux_pop = '0;
            end
        end
        chk(list_avail[1] == 1'b0, "R7 output 1 drained", list_avail[1], 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule